// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block joins two 18-bit ports, A and B, with one independent storage path for each direction. Each path holds a single storage element whose behaviour is set by its own latch enable. With the enable high, the element is a transparent latch and the output follows the input. With the enable low, the element keeps its contents until a falling edge on that path's strobe, which captures new data. Each path therefore supports transparent, latched and clocked transfer.

Each output side has its own output enable. The A-to-B enable is active high and the B-to-A enable is active low. A disabled side reports a low drive flag and an all-zero data vector. Tri-state pins are modelled as a data vector plus a drive flag, so the block can sit behind pad cells.

The strobes and latch enables are sampled by a free-running system clock `clk`. A strobe counts as falling when it is sampled high at one rising edge of `clk` and low at the next. The data present at that second edge is stored, and it appears on the output just after that edge. The transparent path runs from input to output without a register. The reset input is asynchronous, active low, and is released synchronously inside the block.

Top module: `xcvr_top`

## Requirements
- R1: While `oe_ab` is 1 and `le_ab` is 1, `b_out` equals `a_in` in the same cycle, with no clock edge needed.
- R2: While `le_ab` is 1, the A-to-B element loads `a_in` at every rising edge of `clk`. After `le_ab` drops, `b_out` holds the last value loaded while transparent, even if `a_in` changes.
- R3: While `le_ab` is 0, a falling `clk_ab` (sampled 1 at one rising `clk` edge and 0 at the next) stores the `a_in` present at the second edge. That value is on `b_out` after that edge.
- R4: While `le_ab` is 0, a rising `clk_ab` or a steady `clk_ab` level leaves the stored value and `b_out` unchanged.
- R5: If `le_ab` falls while `clk_ab` is 0 and `clk_ab` then stays 0, `b_out` keeps the value it showed just before `le_ab` fell.
- R6: `oe_ab` is active high. `b_oe` equals `oe_ab`, and while `oe_ab` is 0, `b_out` is all zeros, whatever the other inputs are.
- R7: The B-to-A path behaves as in R1 to R5, using `b_in`, `le_ba`, `clk_ba` and outputs `a_out`/`a_oe`.
- R8: `oe_ba_n` is active low. `a_oe` is the inverse of `oe_ba_n`, and while `oe_ba_n` is 1, `a_out` is all zeros.
- R9: After reset, both storage elements read zero, so an enabled output with its latch enable low shows all zeros.
- R10: The two paths are independent. Loading, strobing or changing the enables of one path does not alter the value stored in the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples strobes and latch enables |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | Data seen on the A port |
| b_in | input | 18 | Data seen on the B port |
| oe_ab | input | 1 | B-side output enable, active high |
| oe_ba_n | input | 1 | A-side output enable, active low |
| le_ab | input | 1 | A-to-B latch enable, 1 = transparent |
| le_ba | input | 1 | B-to-A latch enable, 1 = transparent |
| clk_ab | input | 1 | A-to-B capture strobe, falling edge active |
| clk_ba | input | 1 | B-to-A capture strobe, falling edge active |
| b_out | output | 18 | Data driven toward the B port |
| b_oe | output | 1 | B-side drive flag |
| a_out | output | 18 | Data driven toward the A port |
| a_oe | output | 1 | A-side drive flag |

## Verification
The bench targets the moments when the latch enable drops, both with the strobe low and with it high. A design that stops updating the element while transparent would then show stale data instead of the last transparent value. A rising strobe, and a strobe held at one level, are both applied with new input data. A design that captured on the wrong edge, or on a level, would let that data through. The bench checks that a capture appears only after the edge where the fall is seen, and never one cycle early. It checks the opposite enable polarities of the two sides. It also exercises one path heavily while the other holds a value, and then confirms the held value, to catch storage shared or cross-wired between the directions.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // default width of each data path
  parameter int unsigned XCVR_W = 18;
  // number of synchronizer stages on the reset release
  parameter int unsigned XCVR_RST_STAGES = 2;
endpackage

// File: rtl/xcvr_reset_sync.sv
module xcvr_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int unsigned W      = 18,
  parameter bit          OE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         stb,
  input  logic         oe_pin,
  output logic [W-1:0] dout,
  output logic         drive
);
  logic         stb_q;
  logic         stb_fall;
  logic         load;
  logic [W-1:0] hold_q;
  logic [W-1:0] hold_d;
  logic         en;

  // enable polarity picked per direction
  if (OE_LOW) begin : g_oe_low
    assign en = ~oe_pin;
  end else begin : g_oe_high
    assign en = oe_pin;
  end

  // next-state: load while transparent, or on a sampled falling strobe
  always_comb begin
    stb_fall = stb_q & ~stb;
    load     = le | stb_fall;
    hold_d   = hold_q;
    if (load) hold_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      stb_q <= stb;
      if (load) hold_q <= hold_d;
    end
  end

  // output select: input directly when transparent, stored value otherwise
  always_comb begin
    dout  = '0;
    drive = en;
    if (en) dout = le ? din : hold_q;
  end
endmodule

// File: rtl/xcvr_top.sv
module xcvr_top
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         oe_ab,
  input  logic         oe_ba_n,
  input  logic         le_ab,
  input  logic         le_ba,
  input  logic         clk_ab,
  input  logic         clk_ba,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  output logic [W-1:0] a_out,
  output logic         a_oe
);
  logic rst_q_n;

  xcvr_reset_sync #(.STAGES(XCVR_RST_STAGES)) i_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  // A toward B, enable active high
  xcvr_lane #(.W(W), .OE_LOW(1'b0)) i_lane_ab (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .din    (a_in),
    .le     (le_ab),
    .stb    (clk_ab),
    .oe_pin (oe_ab),
    .dout   (b_out),
    .drive  (b_oe)
  );

  // B toward A, enable active low
  xcvr_lane #(.W(W), .OE_LOW(1'b1)) i_lane_ba (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .din    (b_in),
    .le     (le_ba),
    .stb    (clk_ba),
    .oe_pin (oe_ba_n),
    .dout   (a_out),
    .drive  (a_oe)
  );
endmodule

// File: rtl/xcvr_top_chk.sv
module xcvr_top_chk #(
  parameter int unsigned W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         oe_ab,
  input logic         oe_ba_n,
  input logic         le_ab,
  input logic         le_ba,
  input logic         clk_ab,
  input logic         clk_ba,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic [W-1:0] a_out,
  input logic         a_oe
);
  logic ab_q, ba_q;
  logic ab_fall, ba_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_q <= 1'b0;
      ba_q <= 1'b0;
    end else begin
      ab_q <= clk_ab;
      ba_q <= clk_ba;
    end
  end

  assign ab_fall = ab_q & ~clk_ab;
  assign ba_fall = ba_q & ~clk_ba;

  // R1
  ab_transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_ab && le_ab) |-> (b_out == a_in));

  // R3
  ab_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_ab && !le_ab && $past(!le_ab && ab_fall)) |-> (b_out == $past(a_in)));

  // R4
  ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_ab && !le_ab && $past(oe_ab && !le_ab && !ab_fall)) |-> $stable(b_out));

  // R6
  ab_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_ab) |-> (!b_oe && b_out == '0));

  // R7
  ba_transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_ba_n && le_ba) |-> (a_out == b_in));

  // R7
  ba_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_ba_n && !le_ba && $past(!le_ba && ba_fall)) |-> (a_out == $past(b_in)));

  // R7
  ba_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_ba_n && !le_ba && $past(!oe_ba_n && !le_ba && !ba_fall)) |-> $stable(a_out));

  // R8
  ba_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_ba_n) |-> (!a_oe && a_out == '0));
endmodule

bind xcvr_top xcvr_top_chk #(.W(W)) i_xcvr_top_chk (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .a_in    (a_in),
  .b_in    (b_in),
  .oe_ab   (oe_ab),
  .oe_ba_n (oe_ba_n),
  .le_ab   (le_ab),
  .le_ba   (le_ba),
  .clk_ab  (clk_ab),
  .clk_ba  (clk_ba),
  .b_out   (b_out),
  .b_oe    (b_oe),
  .a_out   (a_out),
  .a_oe    (a_oe)
);

// File: tb/test_xcvr_top.sv
`timescale 1ns/1ps
module test_xcvr_top;
  localparam int unsigned W = 18;

  typedef struct {
    string        tag;
    bit           side_b;
    logic [W-1:0] data;
    logic         oe;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_src, b_src;
  logic         a_drv, b_drv;
  logic [W-1:0] a_in, b_in;
  logic         oe_ab, oe_ba_n, le_ab, le_ba, clk_ab, clk_ba;
  logic [W-1:0] b_out, a_out;
  logic         b_oe, a_oe;

  int   n_run  = 0;
  int   n_fail = 0;
  int   clash  = 0;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  // external bus agents: an undriven bus reads zero
  assign a_in = a_drv ? a_src : '0;
  assign b_in = b_drv ? b_src : '0;

  xcvr_top #(.W(W)) i_xcvr_top (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .le_ab(le_ab), .le_ba(le_ba),
    .clk_ab(clk_ab), .clk_ba(clk_ba), .b_out(b_out), .b_oe(b_oe),
    .a_out(a_out), .a_oe(a_oe)
  );

  // contention: device and external agent driving one bus together
  always @(posedge clk) begin
    if (rst_n && ((a_drv && a_oe) || (b_drv && b_oe))) clash++;
  end

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      exp_t e;
      wait (sb_q.size() != 0);
      e = sb_q.pop_front();
      n_run++;
      if (e.side_b) begin
        if (b_out !== e.data || b_oe !== e.oe) begin
          n_fail++;
          $display("FAIL %s b_out=%h b_oe=%b expected %h/%b", e.tag, b_out, b_oe, e.data, e.oe);
        end
      end else begin
        if (a_out !== e.data || a_oe !== e.oe) begin
          n_fail++;
          $display("FAIL %s a_out=%h a_oe=%b expected %h/%b", e.tag, a_out, a_oe, e.data, e.oe);
        end
      end
    end
  end

  task automatic expect_out(input string tag, input bit side_b, input logic [W-1:0] d, input logic oe);
    exp_t e;
    #1;
    e.tag = tag; e.side_b = side_b; e.data = d; e.oe = oe;
    sb_q.push_back(e);
    #0;
  endtask

  task automatic nedge();
    @(negedge clk);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog (all) actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; a_src = '0; b_src = '0; a_drv = 1'b1; b_drv = 1'b0;
    oe_ab = 1'b0; oe_ba_n = 1'b1; le_ab = 1'b0; le_ba = 1'b0;
    clk_ab = 1'b0; clk_ba = 1'b0;
    repeat (3) nedge();
    rst_n = 1'b1;
    repeat (4) nedge();

    // ---- A to B phase ----
    oe_ab = 1'b1; a_src = 18'h2A5C3;
    expect_out("R9 reset clears AB store", 1'b1, '0, 1'b1);
    nedge(); le_ab = 1'b1; a_src = 18'h15A5A;
    expect_out("R1 transparent", 1'b1, 18'h15A5A, 1'b1);
    nedge(); a_src = 18'h3C0F1;
    expect_out("R1 transparent follows", 1'b1, 18'h3C0F1, 1'b1);
    nedge(); le_ab = 1'b0; a_src = 18'h01234;
    expect_out("R2 last transparent held", 1'b1, 18'h3C0F1, 1'b1);
    nedge(); nedge();
    expect_out("R5 le fell with strobe low", 1'b1, 18'h3C0F1, 1'b1);
    nedge(); clk_ab = 1'b1; a_src = 18'h2FEDC;
    expect_out("R4 rising strobe ignored", 1'b1, 18'h3C0F1, 1'b1);
    nedge();
    expect_out("R4 strobe steady high", 1'b1, 18'h3C0F1, 1'b1);
    nedge(); clk_ab = 1'b0;
    expect_out("R3 no capture before edge", 1'b1, 18'h3C0F1, 1'b1);
    nedge(); a_src = 18'h0BEEF;
    expect_out("R3 falling strobe capture", 1'b1, 18'h2FEDC, 1'b1);
    nedge();
    expect_out("R4 strobe steady low", 1'b1, 18'h2FEDC, 1'b1);
    nedge(); oe_ab = 1'b0;
    expect_out("R6 disabled zeros", 1'b1, '0, 1'b0);
    nedge(); le_ab = 1'b1; a_src = 18'h11111;
    expect_out("R6 disabled while transparent", 1'b1, '0, 1'b0);
    nedge(); oe_ab = 1'b1; a_src = 18'h33CC3;
    expect_out("R1 re-enabled transparent", 1'b1, 18'h33CC3, 1'b1);
    nedge(); clk_ab = 1'b1;
    nedge(); le_ab = 1'b0; a_src = 18'h2D2D2;
    expect_out("R2 le fell with strobe high", 1'b1, 18'h33CC3, 1'b1);
    nedge(); clk_ab = 1'b0;
    nedge(); a_src = 18'h00007;
    expect_out("R3 capture after le drop", 1'b1, 18'h2D2D2, 1'b1);

    // ---- B to A phase ----
    nedge(); oe_ab = 1'b0; b_drv = 1'b1; a_drv = 1'b0; oe_ba_n = 1'b0; b_src = 18'h1F00F;
    expect_out("R9 reset clears BA store", 1'b0, '0, 1'b1);
    nedge(); le_ba = 1'b1;
    expect_out("R7 BA transparent", 1'b0, 18'h1F00F, 1'b1);
    nedge(); le_ba = 1'b0; b_src = 18'h24680;
    expect_out("R7 BA latched", 1'b0, 18'h1F00F, 1'b1);
    nedge(); clk_ba = 1'b1;
    nedge(); clk_ba = 1'b0;
    expect_out("R7 BA rising ignored", 1'b0, 18'h1F00F, 1'b1);
    nedge(); b_src = 18'h13579;
    expect_out("R7 BA falling capture", 1'b0, 18'h24680, 1'b1);
    nedge(); oe_ba_n = 1'b1;
    expect_out("R8 active-low enable off", 1'b0, '0, 1'b0);
    nedge(); oe_ba_n = 1'b0;
    expect_out("R8 active-low enable on", 1'b0, 18'h24680, 1'b1);

    // ---- independence ----
    nedge(); oe_ba_n = 1'b1; b_drv = 1'b0; a_drv = 1'b1; oe_ab = 1'b1;
    expect_out("R10 AB store kept across BA use", 1'b1, 18'h2D2D2, 1'b1);
    nedge();

    n_run++;
    if (clash != 0) begin
      n_fail++;
      $display("FAIL R6 R8 bus contention count=%0d expected 0", clash);
    end
    wait (sb_q.size() == 0);
    #1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule